// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block joins two symmetric buses. Each bus carries one data byte and one parity bit. Each direction has its own holding latch. While a latch enable is high, its latch is transparent and the incoming byte and parity pass to the far side. While the enable is low, the latch keeps what it last captured.

A mode input selects the parity bit sent to the far side. It is either freshly generated from the latched byte or the incoming parity bit carried through unchanged. A polarity input selects the odd or even rule. That rule applies both to generation and to the permanent check on each latch. Each latch has its own active-low error flag.

Pads are modelled as separate input, output and drive-enable signals. The latch is modelled on a clock. When its enable is low, it holds the value sampled at the last rising clock edge with the enable high. An asynchronous active-low reset clears both latches, and its release is synchronised to the clock.

Top module: `parity_xcvr`

## Requirements
- R1: With `lat_a_en` high and `oe_b_n` low, `b_out` equals `a_in` in the same cycle, with no clock edge in between.
- R2: With `lat_b_en` high and `oe_a_n` low, `a_out` equals `b_in` in the same cycle (mirror of R1).
- R3: While a latch enable is low, the far-side data and parity outputs keep the value that was on that latch's inputs at the last rising clock edge with the enable high, whatever the inputs do.
- R4: With `feed_thru` = 0, the far-side parity bit is generated from the latched byte. With `odd_sel` = 1 the nine output bits hold an odd number of ones; with `odd_sel` = 0 they hold an even number.
- R5: With `feed_thru` = 1, the far-side parity bit equals the latched incoming parity bit, unchanged.
- R6: `err_a_n` is 0 exactly when the nine bits in the A latch (byte plus parity bit) break the rule chosen by `odd_sel`, and 1 otherwise.
- R7: `err_b_n` follows the same rule for the B latch.
- R8: With `oe_b_n` = 1, `b_drv` is 0 and `b_out` and `b_par_out` read 0. With `oe_b_n` = 0, `b_drv` is 1. The same holds for `oe_a_n` with `a_drv`, `a_out` and `a_par_out`.
- R9: Reset clears both latches to all zeros. After reset with both enables low, `b_out` reads 0 and `err_a_n` is 0 under the odd rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | A-bus data into the A latch |
| a_par_in | input | 1 | A-bus parity into the A latch |
| b_in | input | 8 | B-bus data into the B latch |
| b_par_in | input | 1 | B-bus parity into the B latch |
| lat_a_en | input | 1 | A latch transparent when high |
| lat_b_en | input | 1 | B latch transparent when high |
| feed_thru | input | 1 | 1: pass parity through; 0: generate parity |
| odd_sel | input | 1 | 1: odd rule; 0: even rule |
| oe_a_n | input | 1 | Active-low drive enable for the A side |
| oe_b_n | input | 1 | Active-low drive enable for the B side |
| a_out | output | 8 | Data driven onto A (from the B latch) |
| a_par_out | output | 1 | Parity driven onto A |
| a_drv | output | 1 | A-side drivers enabled |
| b_out | output | 8 | Data driven onto B (from the A latch) |
| b_par_out | output | 1 | Parity driven onto B |
| b_drv | output | 1 | B-side drivers enabled |
| err_a_n | output | 1 | Active-low parity error of the A latch |
| err_b_n | output | 1 | Active-low parity error of the B latch |

## Verification
The assertions assume that the mode and polarity inputs and the bus inputs are steady around each sampling point. They also assume that a side's drive enable is low whenever its parity relation is judged. The bench changes inputs only on falling clock edges and samples a quarter period later, so every combinational path has settled. It drives one direction at a time and always holds the opposite side's drive enable high. The hold checks lower an enable only after a rising edge has captured the intended value.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;
  // Parity bit that makes {data, bit} satisfy the chosen rule.
  function automatic logic make_parity(input logic [7:0] data, input logic odd);
    return (^data) ^ odd;
  endfunction
endpackage

// File: rtl/pxcv_latch.sv
module pxcv_latch #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_nxt;

  always_comb begin
    hold_nxt = hold_q;
    if (en) hold_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_nxt;
  end

  assign q = en ? d : hold_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> $stable(q));
endmodule

// File: rtl/pxcv_parity.sv
module pxcv_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_in,
  input  logic              odd_sel,
  input  logic              feed_thru,
  output logic              par_out,
  output logic              err_n
);
  logic gen_bit;
  logic lane_xor;

  always_comb begin
    gen_bit  = (^data) ^ odd_sel;
    lane_xor = (^data) ^ par_in;
    par_out  = feed_thru ? par_in : gen_bit;
    err_n    = (lane_xor == odd_sel);
  end

  // R6 R7
  err_rule_chk: assert final (err_n === 1'bx || err_n == ((^{data, par_in}) == odd_sel));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  input  logic              a_par_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  input  logic              lat_a_en,
  input  logic              lat_b_en,
  input  logic              feed_thru,
  input  logic              odd_sel,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [DATA_W-1:0] a_out,
  output logic              a_par_out,
  output logic              a_drv,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_drv,
  output logic              err_a_n,
  output logic              err_b_n
);
  localparam int LANE_W = DATA_W + 1;
  localparam int SIDES  = 2;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [LANE_W-1:0] lane_in [SIDES];
  logic [LANE_W-1:0] lane_q  [SIDES];
  logic              lane_en [SIDES];
  logic              par_w   [SIDES];
  logic              err_w   [SIDES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign lane_in[0] = {a_par_in, a_in};
  assign lane_in[1] = {b_par_in, b_in};
  assign lane_en[0] = lat_a_en;
  assign lane_en[1] = lat_b_en;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pxcv_latch #(.WIDTH(LANE_W)) u_lat (
      .clk(clk), .rst_n(rst_int_n), .en(lane_en[s]),
      .d(lane_in[s]), .q(lane_q[s])
    );
    pxcv_parity #(.DATA_W(DATA_W)) u_par (
      .data(lane_q[s][DATA_W-1:0]), .par_in(lane_q[s][DATA_W]),
      .odd_sel(odd_sel), .feed_thru(feed_thru),
      .par_out(par_w[s]), .err_n(err_w[s])
    );
  end

  always_comb begin
    b_drv     = ~oe_b_n;
    a_drv     = ~oe_a_n;
    b_out     = b_drv ? lane_q[0][DATA_W-1:0] : '0;
    b_par_out = b_drv ? par_w[0] : 1'b0;
    a_out     = a_drv ? lane_q[1][DATA_W-1:0] : '0;
    a_par_out = a_drv ? par_w[1] : 1'b0;
    err_a_n   = err_w[0];
    err_b_n   = err_w[1];
  end

  // R8
  b_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !b_drv |-> (b_out == '0 && !b_par_out));
  // R4
  b_gen_rule_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (b_drv && !feed_thru) |-> ((^{b_out, b_par_out}) == odd_sel));
  // R5
  b_feed_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (b_drv && feed_thru && lat_a_en) |-> (b_par_out == a_par_in));
  // R1
  b_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (b_drv && lat_a_en) |-> (b_out == a_in));
  // R2
  a_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (a_drv && lat_b_en) |-> (a_out == b_in));
  // R6
  err_a_live_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lat_a_en |-> (err_a_n == ((^{a_in, a_par_in}) == odd_sel)));
endmodule

// File: tb/parity_xcvr_bench.sv
module parity_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_par_in, b_par_in, lat_a_en, lat_b_en, feed_thru, odd_sel;
  logic       oe_a_n, oe_b_n, a_par_out, b_par_out, a_drv, b_drv, err_a_n, err_b_n;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  parity_xcvr u_parity_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_par_in(a_par_in),
    .b_in(b_in), .b_par_in(b_par_in), .lat_a_en(lat_a_en), .lat_b_en(lat_b_en),
    .feed_thru(feed_thru), .odd_sel(odd_sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_out(a_out), .a_par_out(a_par_out), .a_drv(a_drv), .b_out(b_out),
    .b_par_out(b_par_out), .b_drv(b_drv), .err_a_n(err_a_n), .err_b_n(err_b_n)
  );

  // {byte, par_in, odd_sel, feed_thru, expected parity out, expected err_n}
  localparam logic [12:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h7F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic int ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  function automatic logic want_par(input logic [7:0] v, input logic p, input logic odd, input logic ft);
    if (ft) return p;
    return ((ones(v) % 2) == 1) ? ~odd : odd;
  endfunction

  function automatic logic want_err_n(input logic [7:0] v, input logic p, input logic odd);
    return (((ones(v) + p) % 2) == 1) == odd;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_in = 8'h5A; b_in = 8'hC3; a_par_in = 1'b1; b_par_in = 1'b1;
    lat_a_en = 1'b0; lat_b_en = 1'b0; feed_thru = 1'b0; odd_sel = 1'b1;
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    // R9 reset clears latches: zero byte fails odd rule
    chk("R9 b_out", b_out, 0);
    chk("R9 a_out", a_out, 0);
    chk("R9 err_a_n", err_a_n, 0);
    chk("R9 err_b_n", err_b_n, 0);

    // Table vectors, A to B (R4 R5 R6)
    oe_a_n = 1'b1; lat_a_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {a_in, a_par_in, odd_sel, feed_thru} = VEC[i][12:2];
      #5;
      chk("R1 table data", b_out, VEC[i][12:5]);
      chk(VEC[i][2] ? "R5 table parity" : "R4 table parity", b_par_out, VEC[i][1]);
      chk("R6 table err", err_a_n, VEC[i][0]);
    end

    // Full sweep, both directions, both rules, both modes
    for (int o = 0; o < 2; o++) begin
      for (int f = 0; f < 2; f++) begin
        for (int v = 0; v < 256; v++) begin
          @(negedge clk);
          odd_sel = o[0]; feed_thru = f[0];
          oe_a_n = 1'b1; oe_b_n = 1'b0; lat_a_en = 1'b1; lat_b_en = 1'b0;
          a_in = v[7:0]; a_par_in = v[0] ^ v[3];
          #5;
          chk("R1 sweep", b_out, a_in);
          chk(f ? "R5 sweep" : "R4 sweep", b_par_out, want_par(a_in, a_par_in, o[0], f[0]));
          chk("R6 sweep", err_a_n, want_err_n(a_in, a_par_in, o[0]));
          @(negedge clk);
          oe_a_n = 1'b0; oe_b_n = 1'b1; lat_a_en = 1'b0; lat_b_en = 1'b1;
          b_in = v[7:0]; b_par_in = ~(v[1] ^ v[6]);
          #5;
          chk("R2 sweep", a_out, b_in);
          chk(f ? "R5 sweep B" : "R4 sweep B", a_par_out, want_par(b_in, b_par_in, o[0], f[0]));
          chk("R7 sweep", err_b_n, want_err_n(b_in, b_par_in, o[0]));
        end
      end
    end

    // Single-bit fault injection: correct parity, then flip one bit
    feed_thru = 1'b1; odd_sel = 1'b0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      oe_a_n = 1'b1; oe_b_n = 1'b0; lat_a_en = 1'b1; lat_b_en = 1'b1;
      a_in = 8'h3C; a_par_in = 1'b0; b_in = 8'h81; b_par_in = 1'b0;
      #5;
      chk("R6 clean", err_a_n, 1);
      chk("R7 clean", err_b_n, 1);
      {a_par_in, a_in} = {a_par_in, a_in} ^ (9'd1 << k);
      #2;
      chk("R6 fault", err_a_n, 0);
      chk("R7 unaffected", err_b_n, 1);
      {b_par_in, b_in} = {b_par_in, b_in} ^ (9'd1 << k);
      #2;
      chk("R7 fault", err_b_n, 0);
    end

    // R3 hold: capture 0x96 then drop enable and wiggle inputs
    @(negedge clk);
    odd_sel = 1'b1; feed_thru = 1'b1; oe_b_n = 1'b0; oe_a_n = 1'b1;
    lat_a_en = 1'b1; a_in = 8'h96; a_par_in = 1'b1;
    @(negedge clk);
    lat_a_en = 1'b0; a_in = 8'h11; a_par_in = 1'b0;
    #5;
    chk("R3 hold data", b_out, 8'h96);
    chk("R3 hold parity", b_par_out, 1);
    chk("R3 hold err", err_a_n, 1);
    repeat (3) begin
      @(negedge clk);
      a_in = a_in + 8'h27;
    end
    #5;
    chk("R3 hold later", b_out, 8'h96);
    lat_a_en = 1'b1;
    #2;
    chk("R1 release", b_out, a_in);

    // R8 drivers off
    oe_b_n = 1'b1; oe_a_n = 1'b1;
    #2;
    chk("R8 b_drv", b_drv, 0);
    chk("R8 b_out", b_out, 0);
    chk("R8 b_par_out", b_par_out, 0);
    chk("R8 a_drv", a_drv, 0);
    chk("R8 a_out", a_out, 0);
    oe_b_n = 1'b0;
    #2;
    chk("R8 b_drv on", b_drv, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule